// File: doc/BRIEF.md
# UART Modem Control and Line Status Registers

This block is the host-facing register slice of one channel of a 16450-class serial port. A byte-wide host bus reads and writes a small register file: a line control register whose top bit switches the two lowest offsets over to the divisor latch, an interrupt enable register, a modem control register, a line status register and a modem status view. The bits of the modem control register drive the active-low modem output pins and the interrupt output enable. A loopback bit turns the modem outputs back inward onto the modem status inputs.

Received bytes arrive from an external shift register on a valid/ready stream. The shift register cannot stall, so `rx_ready` is advisory only. It is high while the holding register is empty, or while the host is reading it in that same cycle. A byte presented while `rx_ready` is low is not held back and is not retried. It is dropped, and the overrun flag records the loss. The byte already in the holding register stays intact.

Host reads are combinational on `bus_rdata` in the cycle that `bus_rd` is high. Read side effects take effect at the clock edge that ends that cycle. Register offsets: 0 holds the receive byte (or divisor low), 1 holds the interrupt enable (or divisor high), 3 line control, 4 modem control, 5 line status and 6 modem status. Unused offsets read 0.

Top module: `uart_mctl_lsr`

## Requirements
- R1: After reset, line control, interrupt enable, modem control and line status read 0x00. `dtr_n`, `rts_n` and `op2_n` are 1, `irq_oe` and `irq` are 0, and `rx_ready` is 1.
- R2: With line control bit 7 set, offsets 0 and 1 read and write the divisor low and high bytes. With it clear, they reach the receive holding register and the interrupt enable register (bits 3:0 kept, 7:4 read 0). A read of offset 0 with bit 7 set leaves the data-ready flag alone.
- R3: Outside loopback, `dtr_n` is the inverse of modem control bit 0 and `rts_n` is the inverse of modem control bit 1.
- R4: Modem control bit 3 drives `irq_oe` directly. Outside loopback, `op2_n` is its inverse.
- R5: Modem control bits 7:5 ignore writes and read back 0. Bits 4:0 read back as written.
- R6: A `rx_valid` byte taken while the holding register is empty is loaded into it. Line status bit 0 (data ready) becomes 1 in the next cycle and `rx_ready` falls.
- R7: A `rx_valid` byte arriving while data ready is 1, with no read of offset 0 in that cycle, sets line status bit 1 (overrun). The byte is dropped and the holding register keeps its old byte.
- R8: `irq` is 1 whenever the overrun flag is 1 and interrupt enable bit 2 is 1. It is therefore high in the cycle right after the overrun event.
- R9: Reading offset 0 (bit 7 of line control clear) clears data ready. Reading offset 5 clears overrun. When a new byte or a new overrun arrives in the same cycle as the clearing read, the set wins; a byte arriving with a holding-register read is accepted without overrun.
- R10: With modem control bit 4 set, `dtr_n`, `rts_n` and `op2_n` are held at 1. Modem status bits 4, 5, 6 and 7 then show modem control bits 1, 0, 2 and 3.
- R11: Outside loopback, modem status bits 4, 5, 6 and 7 are the inverses of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`, and bits 3:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| rx_valid | input | 1 | Received byte strobe from the shift register |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Holding register free this cycle |
| cts_n | input | 1 | Clear-to-send input, active low |
| dsr_n | input | 1 | Data-set-ready input, active low |
| ri_n | input | 1 | Ring indicator input, active low |
| dcd_n | input | 1 | Carrier detect input, active low |
| dtr_n | output | 1 | Data-terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| op2_n | output | 1 | General-purpose output 2, active low |
| irq | output | 1 | Interrupt request value |
| irq_oe | output | 1 | Interrupt pin drive enable (0 means high impedance) |

## Verification
The bench aims at the overrun path. It sends a second byte without draining the first and expects the first byte back. A design that overwrote the holding register would return the second byte. It also times a byte against a holding-register read in the same cycle, and an overrun against a status read in the same cycle. A design where the clear beats the set would lose a byte or a flag in those cases. It tests divisor access while a byte is waiting, which catches a read of offset 0 that wrongly consumes the byte. It tests loopback with patterns that tell each modem line from the others, so a swapped route or a pin that is not parked shows at once.

// File: rtl/uart_mc_pkg.sv
package uart_mc_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IER_W  = 4;

  localparam logic [ADDR_W-1:0] OFF_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_IE    = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_LCTL  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_MCTL  = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_LSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_MSTAT = 3'd6;

  localparam int unsigned DLAB_BIT   = 7;
  localparam int unsigned IE_LSI_BIT = 2;

  typedef struct packed {
    logic loop;
    logic op2;
    logic op1;
    logic rts;
    logic dtr;
  } mctl_t;

  localparam int unsigned MCTL_W = $bits(mctl_t);
endpackage

// File: rtl/uart_hostregs.sv
module uart_hostregs
  import uart_mc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lcr_q,
  output logic [IER_W-1:0]  ier_q,
  output mctl_t             mctl_q,
  output logic [DATA_W-1:0] dll_q,
  output logic [DATA_W-1:0] dlm_q
);
  logic dlab;
  assign dlab = lcr_q[DLAB_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q  <= '0;
      ier_q  <= '0;
      mctl_q <= '0;
      dll_q  <= '0;
      dlm_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFF_DATA: if (dlab) dll_q <= wdata;
        OFF_IE: begin
          if (dlab) dlm_q <= wdata;
          else      ier_q <= wdata[IER_W-1:0];
        end
        OFF_LCTL: lcr_q  <= wdata;
        OFF_MCTL: mctl_q <= mctl_t'(wdata[MCTL_W-1:0]);
        default: ;
      endcase
    end
  end

  a_r2_dlab_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_LCTL) |=> (dlab == $past(wdata[DLAB_BIT])));

  a_r2_ier_kept_in_dlab: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_IE && dlab) |=> $stable(ier_q));
endmodule

// File: rtl/uart_rxhold.sv
module uart_rxhold
  import uart_mc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              rhr_rd,
  input  logic              lsr_rd,
  output logic [DATA_W-1:0] rhr_q,
  output logic              dr_q,
  output logic              ovr_q
);
  logic accept;
  logic overrun_evt;

  assign rx_ready    = !dr_q || rhr_rd;
  assign accept      = rx_valid && rx_ready;
  assign overrun_evt = rx_valid && !rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rhr_q <= '0;
      dr_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (accept) rhr_q <= rx_data;

      if (accept)      dr_q <= 1'b1;
      else if (rhr_rd) dr_q <= 1'b0;

      if (overrun_evt) ovr_q <= 1'b1;
      else if (lsr_rd) ovr_q <= 1'b0;
    end
  end

  a_r6_accept_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !dr_q) |=> (dr_q && rhr_q == $past(rx_data)));

  a_r7_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && dr_q && !rhr_rd) |=> (ovr_q && $stable(rhr_q)));

  a_r9_lsr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !(rx_valid && dr_q && !rhr_rd)) |=> !ovr_q);

  a_r9_rhr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rhr_rd && !rx_valid) |=> !dr_q);
endmodule

// File: rtl/uart_modem_route.sv
module uart_modem_route
  import uart_mc_pkg::*;
(
  input  mctl_t      mctl,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       op2_n,
  output logic       irq_oe,
  output logic [3:0] msr_hi
);
  logic cts, dsr, ri, dcd;

  always_comb begin
    if (mctl.loop) begin
      dtr_n = 1'b1;
      rts_n = 1'b1;
      op2_n = 1'b1;
      cts   = mctl.rts;
      dsr   = mctl.dtr;
      ri    = mctl.op1;
      dcd   = mctl.op2;
    end else begin
      dtr_n = !mctl.dtr;
      rts_n = !mctl.rts;
      op2_n = !mctl.op2;
      cts   = !cts_n;
      dsr   = !dsr_n;
      ri    = !ri_n;
      dcd   = !dcd_n;
    end
  end

  assign irq_oe = mctl.op2;
  assign msr_hi = {dcd, ri, dsr, cts};

  always_comb begin
    a_r10_loop_pins_parked: assert (!mctl.loop || (dtr_n && rts_n && op2_n));
  end
endmodule

// File: rtl/uart_mctl_lsr.sv
module uart_mctl_lsr
  import uart_mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       op2_n,
  output logic       irq,
  output logic       irq_oe
);
  logic [DATA_W-1:0] lcr_q, dll_q, dlm_q, rhr_q;
  logic [IER_W-1:0]  ier_q;
  mctl_t             mctl_q;
  logic              dr_q, ovr_q, dlab, rhr_rd, lsr_rd;
  logic [3:0]        msr_hi;

  assign dlab   = lcr_q[DLAB_BIT];
  assign rhr_rd = bus_rd && bus_addr == OFF_DATA && !dlab;
  assign lsr_rd = bus_rd && bus_addr == OFF_LSTAT;

  uart_hostregs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .lcr_q(lcr_q), .ier_q(ier_q), .mctl_q(mctl_q), .dll_q(dll_q), .dlm_q(dlm_q)
  );

  uart_rxhold u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .rhr_rd(rhr_rd), .lsr_rd(lsr_rd),
    .rhr_q(rhr_q), .dr_q(dr_q), .ovr_q(ovr_q)
  );

  uart_modem_route u_modem (
    .mctl(mctl_q), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .op2_n(op2_n), .irq_oe(irq_oe), .msr_hi(msr_hi)
  );

  assign irq = ier_q[IE_LSI_BIT] && ovr_q;

  always_comb begin
    case (bus_addr)
      OFF_DATA:  bus_rdata = dlab ? dll_q : rhr_q;
      OFF_IE:    bus_rdata = dlab ? dlm_q : {{(DATA_W-IER_W){1'b0}}, ier_q};
      OFF_LCTL:  bus_rdata = lcr_q;
      OFF_MCTL:  bus_rdata = {{(DATA_W-MCTL_W){1'b0}}, mctl_q};
      OFF_LSTAT: bus_rdata = {{(DATA_W-2){1'b0}}, ovr_q, dr_q};
      OFF_MSTAT: bus_rdata = {msr_hi, 4'b0000};
      default:   bus_rdata = '0;
    endcase
  end

  a_r3_pins_follow_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_MCTL && !bus_wdata[4]) |=>
      (dtr_n == !$past(bus_wdata[0]) && rts_n == !$past(bus_wdata[1])));

  a_r4_irq_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_MCTL) |=> (irq_oe == $past(bus_wdata[3])));

  a_r5_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_MCTL) |=> (mctl_q == $past(bus_wdata[4:0])));

  a_r8_irq_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && ier_q[IE_LSI_BIT]) |=> irq);
endmodule

// File: tb/sim_uart_mctl_lsr.sv
`timescale 1ns/1ps
module sim_uart_mctl_lsr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, rx_valid = 1'b0;
  logic [7:0] bus_wdata = '0, rx_data = '0;
  logic [7:0] bus_rdata;
  logic rx_ready, dtr_n, rts_n, op2_n, irq, irq_oe;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  uart_mctl_lsr u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .op2_n(op2_n), .irq(irq), .irq_oe(irq_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result against the scoreboard queue
  always @(negedge clk) begin
    if (bus_rd) begin
      if (exp_q.size() == 0) chk("scoreboard-empty", bus_rdata, 8'hxx);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd_rx(input logic [2:0] a, input logic [7:0] exp, input string tag,
                       input bit with_rx, input logic [7:0] b);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    rx_valid = with_rx; rx_data = b;
    @(posedge clk); #2;
    bus_rd = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_rx(a, exp, tag, 1'b0, 8'h00);
  endtask

  task automatic rx(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1;
    @(posedge clk); #2;
    rx_valid = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    chk("R1 dtr_n", {7'd0, dtr_n}, 8'd1);
    chk("R1 rts_n", {7'd0, rts_n}, 8'd1);
    chk("R1 op2_n", {7'd0, op2_n}, 8'd1);
    chk("R1 irq_oe", {7'd0, irq_oe}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 rx_ready", {7'd0, rx_ready}, 8'd1);
    rd(3'd3, 8'h00, "R1 lcr");
    rd(3'd4, 8'h00, "R1 mcr");
    rd(3'd5, 8'h00, "R1 lsr");
    rd(3'd1, 8'h00, "R1 ier");
    // R2 divisor access
    wr(3'd3, 8'h80); wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    rd(3'd0, 8'h34, "R2 dll");
    rd(3'd1, 8'h12, "R2 dlm");
    wr(3'd3, 8'h03); wr(3'd1, 8'hF4);
    rd(3'd1, 8'h04, "R2 ier");
    rd(3'd3, 8'h03, "R2 lcr");
    // R3 / R4 modem outputs
    wr(3'd4, 8'h01);
    chk("R3 dtr_n low", {7'd0, dtr_n}, 8'd0);
    chk("R3 rts_n high", {7'd0, rts_n}, 8'd1);
    wr(3'd4, 8'h02);
    chk("R3 dtr_n high", {7'd0, dtr_n}, 8'd1);
    chk("R3 rts_n low", {7'd0, rts_n}, 8'd0);
    wr(3'd4, 8'h08);
    chk("R4 irq_oe", {7'd0, irq_oe}, 8'd1);
    chk("R4 op2_n", {7'd0, op2_n}, 8'd0);
    // R5 reserved bits
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h1F, "R5 mcr readback");
    chk("R10 pins parked", {5'd0, dtr_n, rts_n, op2_n}, 8'h07);
    wr(3'd4, 8'h00);
    // R6 accept
    rx(8'hA5);
    chk("R6 rx_ready low", {7'd0, rx_ready}, 8'd0);
    rd(3'd5, 8'h01, "R6 data ready");
    rd(3'd0, 8'hA5, "R6 byte");
    rd(3'd5, 8'h00, "R9 dr cleared");
    chk("R6 rx_ready high", {7'd0, rx_ready}, 8'd1);
    // R7 / R8 overrun with interrupt enabled (IER=0x04)
    rx(8'h11); rx(8'h22);
    chk("R8 irq on overrun", {7'd0, irq}, 8'd1);
    rd(3'd5, 8'h03, "R7 overrun flag");
    chk("R9 irq drops after lsr read", {7'd0, irq}, 8'd0);
    rd(3'd5, 8'h01, "R9 overrun cleared");
    rd(3'd0, 8'h11, "R7 old byte kept");
    // R8 with interrupt disabled
    wr(3'd1, 8'h00);
    rx(8'h33); rx(8'h44);
    chk("R8 irq masked", {7'd0, irq}, 8'd0);
    rd(3'd5, 8'h03, "R7 overrun masked irq");
    rd(3'd0, 8'h33, "R7 old byte kept 2");
    // R9 same-cycle races
    rx(8'h55);
    rd_rx(3'd0, 8'h55, "R9 read with arrival", 1'b1, 8'h66);
    rd(3'd5, 8'h01, "R9 arrival accepted");
    rd(3'd0, 8'h66, "R9 new byte");
    rx(8'h77);
    rd_rx(3'd5, 8'h01, "R9 lsr read with overrun", 1'b1, 8'h88);
    rd(3'd5, 8'h03, "R9 set beats clear");
    rd(3'd0, 8'h77, "R9 byte kept");
    // R2 divisor read does not consume byte
    rx(8'h99);
    wr(3'd3, 8'h83);
    rd(3'd0, 8'h34, "R2 dll while byte waits");
    wr(3'd3, 8'h03);
    rd(3'd5, 8'h01, "R2 dr untouched");
    rd(3'd0, 8'h99, "R2 byte intact");
    // R10 loopback
    wr(3'd4, 8'h15);
    rd(3'd6, 8'h60, "R10 dtr->dsr op1->ri");
    chk("R10 dtr_n parked", {7'd0, dtr_n}, 8'd1);
    wr(3'd4, 8'h1A);
    rd(3'd6, 8'h90, "R10 rts->cts op2->dcd");
    chk("R10 rts/op2 parked", {6'd0, rts_n, op2_n}, 8'h03);
    // R11 external modem inputs
    wr(3'd4, 8'h00);
    cts_n = 1'b0; ri_n = 1'b0; #2;
    rd(3'd6, 8'h50, "R11 cts ri");
    cts_n = 1'b1; ri_n = 1'b1; dsr_n = 1'b0; dcd_n = 1'b0; #2;
    rd(3'd6, 8'hA0, "R11 dsr dcd");
    rd(3'd7, 8'h00, "R11 unused offset");
    @(posedge clk); #2;
    if (exp_q.size() != 0) chk("scoreboard-leftover", 8'(exp_q.size()), 8'd0);
    summary();
  end
endmodule